// File: doc/BRIEF.md
# Fast-Lock Charge-Pump Current Controller

This block decides which of two 3-bit charge-pump current codes reaches the charge pump. The analog stage sets its current to a minimum step times (code + 1), so each code picks one of 8 steps. In the plain mode, a stored gain bit selects the normal code or the boost code. In the fast-lock mode, a write of the gain bit as 1 starts an interval. The interval is counted in phase-detector comparison periods, which arrive as single-cycle ticks. During the interval the block selects the boost code and turns on the loop-filter switch. When the interval ends it returns to the normal code, turns the switch off and sends a one-cycle pulse that clears the gain bit in the register file.

The interval length is 3 + 4×TIMER ticks, which runs from 3 to 63. A write to the initialization register stops the timer and requests charge-pump tristate. The next frequency-word write releases the tristate and starts the timer if fast lock is armed.

Top module: `fastlock_cp_ctrl`

## Requirements
- R1: After reset, `cp_code_o` equals `code_norm_i`, and `lf_switch_o`, `cp_tristate_o` and `gain_clr_o` are 0.
- R2: When `fast_mode_i` is not 2'b11, the stored gain bit (last value written with `gain_wr_i`) selects the code: 0 gives `code_norm_i`, 1 gives `code_boost_i`. `lf_switch_o` stays 0 and `gain_clr_o` never pulses.
- R3: With `fast_mode_i` = 2'b11 and no tristate hold, a write of gain bit 1 arms the interval. From the next cycle, `cp_code_o` = `code_boost_i` and `lf_switch_o` = 1.
- R4: The interval ends on the (3 + 4×`timer_sel_i`)-th `pfd_tick_i` after the arming write. A tick in the same cycle as the arming write is not counted.
- R5: In the cycle after the last tick, `lf_switch_o` drops to 0, `cp_code_o` returns to `code_norm_i`, and `gain_clr_o` is 1 for exactly one cycle. The stored gain bit is cleared, so leaving fast mode afterwards selects `code_norm_i`.
- R6: An arming write while an interval runs restarts the count from zero.
- R7: An arming write in the same cycle as the expiring tick wins. The count restarts and no clear pulse is issued.
- R8: `init_wr_i` sets `cp_tristate_o` from the next cycle and stops any running interval without a clear pulse. While the hold is active, an arming write stores the gain bit but does not start the timer.
- R9: `freq_wr_i` clears `cp_tristate_o` from the next cycle. If the stored gain bit (or a gain bit written in the same cycle) is 1 and `fast_mode_i` = 2'b11, it also starts the interval.
- R10: If `fast_mode_i` leaves 2'b11 during an interval, the interval stops without a clear pulse. The gain bit, still 1, then selects `code_boost_i` statically.
- R11: The selected code is passed through unchanged for all 8 code values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pfd_tick_i | input | 1 | One-cycle pulse per phase-detector period |
| fast_mode_i | input | 2 | Fast-lock mode field; 2'b11 enables the timer |
| gain_wr_i | input | 1 | Write strobe for the gain bit |
| gain_bit_i | input | 1 | Gain bit value written with `gain_wr_i` |
| timer_sel_i | input | 4 | Interval select; length 3 + 4×value ticks |
| code_norm_i | input | 3 | Normal current code |
| code_boost_i | input | 3 | Fast-lock current code |
| init_wr_i | input | 1 | Initialization-register write strobe |
| freq_wr_i | input | 1 | Frequency-word write strobe |
| cp_code_o | output | 3 | Active current code |
| lf_switch_o | output | 1 | Loop-filter switch enable |
| cp_tristate_o | output | 1 | Charge-pump tristate request |
| gain_clr_o | output | 1 | One-cycle clear pulse for the gain bit |

## Verification
Interval expiry and a new arming write can land in the same clock cycle. The bench provokes this by counting ticks up to one short of the limit. It then drives the expiring tick and a gain write of 1 together. It judges the outcome at the ports: no clear pulse may appear, and the switch stays on. The switch must stay on through exactly a full new interval, a check that also confirms the tick in that cycle was not counted. The bench pairs a tick with an ordinary arming write in the same way to confirm that such ticks are dropped.

// File: rtl/fl_cp_pkg.sv
package fl_cp_pkg;
  localparam logic [1:0] FAST_ARMED = 2'b11;

  typedef enum logic {
    CUR_NORMAL = 1'b0,
    CUR_BOOST  = 1'b1
  } cur_sel_e;
endpackage

// File: rtl/fl_interval_timer.sv
module fl_interval_timer #(
  parameter int unsigned TSEL_W = 4,
  localparam int unsigned CNT_W = TSEL_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              tick_i,
  input  logic [TSEL_W-1:0] sel_i,
  output logic              run_o,
  output logic              expire_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;

  // length = 4*sel + 3, so last index = 4*sel + 2
  assign last_idx = {sel_i, 2'b10};
  assign expire_o = run_q & tick_i & (cnt_q == last_idx) & ~start_i & ~stop_i;
  assign run_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (expire_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fl_ctrl_state.sv
module fl_ctrl_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_wr_i,
  input  logic freq_wr_i,
  input  logic gain_wr_i,
  input  logic gain_bit_i,
  input  logic expire_i,
  output logic hold_o,
  output logic gain_o,
  output logic clr_o
);
  logic hold_q, gain_q, clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      gain_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      if (init_wr_i)      hold_q <= 1'b1;
      else if (freq_wr_i) hold_q <= 1'b0;

      if (gain_wr_i)     gain_q <= gain_bit_i;
      else if (expire_i) gain_q <= 1'b0;

      clr_q <= expire_i;
    end
  end

  assign hold_o = hold_q;
  assign gain_o = gain_q;
  assign clr_o  = clr_q;
endmodule

// File: rtl/fl_code_mux.sv
module fl_code_mux
  import fl_cp_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  cur_sel_e          sel_i,
  input  logic [CODE_W-1:0] norm_i,
  input  logic [CODE_W-1:0] boost_i,
  output logic [CODE_W-1:0] code_o
);
  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    assign code_o[b] = (sel_i == CUR_BOOST) ? boost_i[b] : norm_i[b];
  end
endmodule

// File: rtl/fastlock_cp_ctrl.sv
module fastlock_cp_ctrl
  import fl_cp_pkg::*;
#(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned TSEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pfd_tick_i,
  input  logic [1:0]        fast_mode_i,
  input  logic              gain_wr_i,
  input  logic              gain_bit_i,
  input  logic [TSEL_W-1:0] timer_sel_i,
  input  logic [CODE_W-1:0] code_norm_i,
  input  logic [CODE_W-1:0] code_boost_i,
  input  logic              init_wr_i,
  input  logic              freq_wr_i,
  output logic [CODE_W-1:0] cp_code_o,
  output logic              lf_switch_o,
  output logic              cp_tristate_o,
  output logic              gain_clr_o
);
  logic     fast_on, gain_eff, start, stop;
  logic     hold, gain, run, expire;
  cur_sel_e sel;

  assign fast_on  = (fast_mode_i == FAST_ARMED);
  assign gain_eff = gain_wr_i ? gain_bit_i : gain;
  assign stop     = init_wr_i | ~fast_on;
  assign start    = fast_on & ~init_wr_i &
                    ((gain_wr_i & gain_bit_i & ~hold) | (freq_wr_i & gain_eff));

  fl_interval_timer #(.TSEL_W(TSEL_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .stop_i   (stop),
    .tick_i   (pfd_tick_i),
    .sel_i    (timer_sel_i),
    .run_o    (run),
    .expire_o (expire)
  );

  fl_ctrl_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_wr_i  (init_wr_i),
    .freq_wr_i  (freq_wr_i),
    .gain_wr_i  (gain_wr_i),
    .gain_bit_i (gain_bit_i),
    .expire_i   (expire),
    .hold_o     (hold),
    .gain_o     (gain),
    .clr_o      (gain_clr_o)
  );

  // fast mode: timer owns the select; else gain bit is static selector
  assign sel = (fast_on ? run : gain) ? CUR_BOOST : CUR_NORMAL;

  fl_code_mux #(.CODE_W(CODE_W)) u_mux (
    .sel_i   (sel),
    .norm_i  (code_norm_i),
    .boost_i (code_boost_i),
    .code_o  (cp_code_o)
  );

  assign lf_switch_o   = fast_on & run;
  assign cp_tristate_o = hold;
endmodule

// File: rtl/fl_cp_checker.sv
module fl_cp_checker #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned TSEL_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pfd_tick_i,
  input logic [1:0]        fast_mode_i,
  input logic              gain_wr_i,
  input logic              gain_bit_i,
  input logic [TSEL_W-1:0] timer_sel_i,
  input logic [CODE_W-1:0] code_norm_i,
  input logic [CODE_W-1:0] code_boost_i,
  input logic              init_wr_i,
  input logic              freq_wr_i,
  input logic [CODE_W-1:0] cp_code_o,
  input logic              lf_switch_o,
  input logic              cp_tristate_o,
  input logic              gain_clr_o
);
  a_r5_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_clr_o |=> !gain_clr_o);

  a_r5_clr_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_clr_o |-> ($past(lf_switch_o) && !lf_switch_o));

  a_r2_no_clr_static: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_mode_i != 2'b11) |=> !gain_clr_o);

  a_r3_rise_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lf_switch_o) |-> $past(gain_wr_i || freq_wr_i));

  a_r8_init_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_wr_i |=> (cp_tristate_o && !lf_switch_o));

  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_wr_i && !init_wr_i) |=> !cp_tristate_o);
endmodule

bind fastlock_cp_ctrl fl_cp_checker #(.CODE_W(CODE_W), .TSEL_W(TSEL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pfd_tick_i   (pfd_tick_i),
  .fast_mode_i  (fast_mode_i),
  .gain_wr_i    (gain_wr_i),
  .gain_bit_i   (gain_bit_i),
  .timer_sel_i  (timer_sel_i),
  .code_norm_i  (code_norm_i),
  .code_boost_i (code_boost_i),
  .init_wr_i    (init_wr_i),
  .freq_wr_i    (freq_wr_i),
  .cp_code_o    (cp_code_o),
  .lf_switch_o  (lf_switch_o),
  .cp_tristate_o(cp_tristate_o),
  .gain_clr_o   (gain_clr_o)
);

// File: tb/fastlock_cp_ctrl_tb.sv
`timescale 1ns/1ps
module fastlock_cp_ctrl_tb;
  logic       clk = 0, rst_ni = 0;
  logic       pfd_tick_i = 0, gain_wr_i = 0, gain_bit_i = 0;
  logic       init_wr_i = 0, freq_wr_i = 0;
  logic [1:0] fast_mode_i = 2'b00;
  logic [3:0] timer_sel_i = 0;
  logic [2:0] code_norm_i = 3'd1, code_boost_i = 3'd6;
  logic [2:0] cp_code_o;
  logic       lf_switch_o, cp_tristate_o, gain_clr_o;
  int total = 0, bad = 0, clr_cnt = 0;

  always #4 clk = ~clk;

  fastlock_cp_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pfd_tick_i(pfd_tick_i),
    .fast_mode_i(fast_mode_i), .gain_wr_i(gain_wr_i), .gain_bit_i(gain_bit_i),
    .timer_sel_i(timer_sel_i), .code_norm_i(code_norm_i), .code_boost_i(code_boost_i),
    .init_wr_i(init_wr_i), .freq_wr_i(freq_wr_i), .cp_code_o(cp_code_o),
    .lf_switch_o(lf_switch_o), .cp_tristate_o(cp_tristate_o), .gain_clr_o(gain_clr_o));

  always @(posedge clk) if (rst_ni && gain_clr_o) clr_cnt++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one cycle with chosen strobes, returns at the next negedge
  task automatic cyc(input logic tk, input logic gw, input logic gb,
                     input logic iw, input logic fw);
    pfd_tick_i = tk; gain_wr_i = gw; gain_bit_i = gb; init_wr_i = iw; freq_wr_i = fw;
    @(negedge clk);
    pfd_tick_i = 0; gain_wr_i = 0; gain_bit_i = 0; init_wr_i = 0; freq_wr_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 code", cp_code_o, code_norm_i);
    check("R1 sw", lf_switch_o, 0);
    check("R1 tri", cp_tristate_o, 0);
    check("R1 clr", gain_clr_o, 0);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic t_static;
    int c0;
    c0 = clr_cnt;
    fast_mode_i = 2'b01;
    cyc(0, 1, 1, 0, 0);
    check("R2 gain1 code", cp_code_o, code_boost_i);
    check("R2 sw off", lf_switch_o, 0);
    ticks(5);
    check("R2 no clr", clr_cnt - c0, 0);
    check("R2 still boost", cp_code_o, code_boost_i);
    cyc(0, 1, 0, 0, 0);
    check("R2 gain0 code", cp_code_o, code_norm_i);
    for (int v = 0; v < 8; v++) begin
      code_norm_i = 3'(v); code_boost_i = 3'(7 - v);
      cyc(0, 1, v[0], 0, 0);
      check("R11 pass", cp_code_o, v[0] ? 7 - v : v);
    end
    code_norm_i = 3'd1; code_boost_i = 3'd6;
  endtask

  task automatic t_interval(input int sel);
    int len, c0;
    len = 3 + 4 * sel;
    c0 = clr_cnt;
    fast_mode_i = 2'b11; timer_sel_i = 4'(sel);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 1, 1, 0, 0);  // tick together with arm: not counted
    check("R3 sw on", lf_switch_o, 1);
    check("R3 boost", cp_code_o, code_boost_i);
    ticks(len - 1);
    check("R4 before end", lf_switch_o, 1);
    cyc(1, 0, 0, 0, 0);
    check("R4 end sw", lf_switch_o, 0);
    check("R5 code norm", cp_code_o, code_norm_i);
    check("R5 clr pulse", gain_clr_o, 1);
    cyc(0, 0, 0, 0, 0);
    check("R5 clr once", gain_clr_o, 0);
    check("R5 clr count", clr_cnt - c0, 1);
    fast_mode_i = 2'b00;
    cyc(0, 0, 0, 0, 0);
    check("R5 gain cleared", cp_code_o, code_norm_i);
  endtask

  task automatic t_restart;
    int c0;
    c0 = clr_cnt;
    fast_mode_i = 2'b11; timer_sel_i = 4'd1;  // 7 ticks
    cyc(0, 1, 1, 0, 0);
    ticks(5);
    cyc(0, 1, 1, 0, 0);
    ticks(6);
    check("R6 restarted", lf_switch_o, 1);
    ticks(1);
    check("R6 end", lf_switch_o, 0);
    check("R6 one clr", clr_cnt - c0, 1);
  endtask

  task automatic t_collision;
    int c0;
    fast_mode_i = 2'b11; timer_sel_i = 4'd0;
    cyc(0, 1, 1, 0, 0);
    ticks(2);
    c0 = clr_cnt;
    cyc(1, 1, 1, 0, 0);  // expiring tick + rearm
    check("R7 sw kept", lf_switch_o, 1);
    check("R7 no clr", gain_clr_o, 0);
    ticks(2);
    check("R7 full new interval", lf_switch_o, 1);
    check("R7 no clr count", clr_cnt - c0, 0);
    ticks(1);
    check("R7 end", lf_switch_o, 0);
  endtask

  task automatic t_init;
    int c0;
    fast_mode_i = 2'b11; timer_sel_i = 4'd0;
    cyc(0, 1, 1, 0, 0);
    ticks(1);
    c0 = clr_cnt;
    cyc(0, 0, 0, 1, 0);
    check("R8 tri", cp_tristate_o, 1);
    check("R8 stop", lf_switch_o, 0);
    cyc(0, 1, 1, 0, 0);
    check("R8 held no start", lf_switch_o, 0);
    ticks(4);
    check("R8 no clr", clr_cnt - c0, 0);
    cyc(0, 0, 0, 0, 1);
    check("R9 release", cp_tristate_o, 0);
    check("R9 start", lf_switch_o, 1);
    ticks(3);
    check("R9 expire", lf_switch_o, 0);
    check("R9 clr", clr_cnt - c0, 1);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1);
    check("R9 no arm no start", lf_switch_o, 0);
  endtask

  task automatic t_leave;
    int c0;
    fast_mode_i = 2'b11; timer_sel_i = 4'd2;
    cyc(0, 1, 1, 0, 0);
    ticks(3);
    c0 = clr_cnt;
    fast_mode_i = 2'b10;
    cyc(0, 0, 0, 0, 0);
    check("R10 sw off", lf_switch_o, 0);
    check("R10 static boost", cp_code_o, code_boost_i);
    ticks(12);
    check("R10 no clr", clr_cnt - c0, 0);
  endtask

  initial begin
    t_reset();
    t_static();
    t_interval(0);
    t_interval(2);
    t_interval(15);
    t_restart();
    t_collision();
    t_init();
    t_leave();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule